// File: doc/BRIEF.md
# Doorbell Mailbox With Acknowledge

This block is a register-mapped hand-off point between a host processor and a helper controller. The host loads a four-byte request (an operation byte, a bit-field byte, a target address byte and a data byte), then rings a doorbell by writing a one to the mailbox bit of a set register. While the doorbell is pending, the request is presented on a responder port together with the bank number and read/write flag decoded from the operation byte. The helper accepts the request with a one-cycle consume strobe.

When the helper finishes, it pulses an acknowledge strobe. That strobe loads a four-byte acknowledge area (status, encoded bank, target address and value) and sets the mailbox bit in an acknowledge value register. The host removes the acknowledge by writing a one to the same bit of a clear register. An interrupt line is raised while the acknowledge is pending and the host has enabled it.

The host must wait for the doorbell bit to drop before it issues the next request, and it must clear any stale acknowledge first. The block enforces part of this itself: the request bytes cannot be written while a doorbell is pending.

Top module: `mbx_doorbell`

## Requirements
- R1: After synchronous reset, every register reads 0, and `req_valid` and `irq` are low.
- R2: Word offsets 0, 1, 2 and 3 hold the operation, bit-field, target and data bytes. Each offset stores `host_wdata` on a write and reads it back. The bytes drive `req_op`, `req_fields`, `req_target` and `req_data`.
- R3: A write to offset 4 (doorbell set) with bit 5 set makes `req_valid` high and makes offset 5 (doorbell value) read 0x20 from the next cycle on. Bits other than bit 5 have no effect, and offset 4 reads 0.
- R4: A `rsp_consume` pulse while the doorbell is pending clears it in the next cycle. A consume pulse while the doorbell is idle has no effect. A doorbell set in the same cycle as a consume leaves the doorbell pending.
- R5: Writes to offsets 0 to 3 are ignored while the doorbell is pending.
- R6: A `rsp_ack` pulse loads `rsp_status`, `rsp_bank`, `rsp_target` and `rsp_value` into offsets 8, 9, 10 and 11, and makes offset 6 (acknowledge value) read 0x20. The host recovers the bank by shifting the offset 9 byte right by one.
- R7: A write to offset 7 (acknowledge clear) with bit 5 set clears the pending acknowledge. Other bits have no effect, and offset 7 reads 0.
- R8: When `rsp_ack` and an acknowledge clear fall in the same cycle, the acknowledge stays pending and the new acknowledge bytes are loaded.
- R9: `irq` is high exactly when the acknowledge is pending and bit 0 of offset 12 (interrupt enable) is 1. Offset 12 reads back that bit.
- R10: The operation byte is encoded as bit 6 = 1, bits 5 to 1 = bank, and bit 0 = 1 for a read and 0 for a write. `req_bank` outputs bits 5 to 1 of the stored operation byte, and `req_read` outputs bit 0.
- R11: Offsets 13 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; `host_rdata` is valid the cycle after |
| host_addr | input | 4 | Host word offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| req_valid | output | 1 | Doorbell pending toward the helper |
| req_op | output | 8 | Operation byte |
| req_fields | output | 8 | Bit-field byte |
| req_target | output | 8 | Target address byte |
| req_data | output | 8 | Write data byte |
| req_bank | output | 5 | Bank decoded from the operation byte |
| req_read | output | 1 | Read flag decoded from the operation byte |
| rsp_consume | input | 1 | Helper accepts the pending request |
| rsp_ack | input | 1 | Helper completion strobe |
| rsp_status | input | 8 | Completion status byte |
| rsp_bank | input | 8 | Encoded bank byte echoed back |
| rsp_target | input | 8 | Target address echoed back |
| rsp_value | input | 8 | Returned value |
| irq | output | 1 | Acknowledge interrupt |

## Verification
If the doorbell flag is wrong, it shows on `req_valid` in the first cycle after the write or consume that should have changed it. It also shows on the doorbell value read, one cycle after the read strobe. If the request bytes are corrupted or locked at the wrong time, `req_op` through `req_data` and the decoded bank and read flag show it directly. A wrong acknowledge flag or enable shows on `irq` in the cycle after the strobe or clear. A dropped set-over-clear priority shows there as a missing interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W    = 8;
    localparam int BANK_W    = 5;
    localparam int REQ_BYTES = 4;

    // Word offsets of the host register file
    localparam int OFF_REQ_BASE  = 0;
    localparam int OFF_DB_SET    = 4;
    localparam int OFF_DB_VAL    = 5;
    localparam int OFF_ACK_FLAG  = 6;
    localparam int OFF_ACK_CLR   = 7;
    localparam int OFF_ACK_STAT  = 8;
    localparam int OFF_ACK_BANK  = 9;
    localparam int OFF_ACK_TGT   = 10;
    localparam int OFF_ACK_DATA  = 11;
    localparam int OFF_IRQ_EN    = 12;

    // Position of the fixed marker bit in an operation byte
    localparam int OP_MARK_BIT = 6;

    typedef struct packed {
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] fields;
        logic [BYTE_W-1:0] target;
        logic [BYTE_W-1:0] data;
    } req_area_t;

    typedef struct packed {
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] bank;
        logic [BYTE_W-1:0] target;
        logic [BYTE_W-1:0] value;
    } ack_area_t;

    function automatic logic [BANK_W-1:0] op_bank(input logic [BYTE_W-1:0] op);
        return op[BANK_W:1];
    endfunction

    function automatic logic op_is_read(input logic [BYTE_W-1:0] op);
        return op[0];
    endfunction

    function automatic logic [BYTE_W-1:0] make_op(input logic [BANK_W-1:0] bank,
                                                  input logic              rd);
        logic [BYTE_W-1:0] v;
        v              = '0;
        v[BANK_W:1]    = bank;
        v[0]           = rd;
        v[OP_MARK_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mbx_req_regs.sv
module mbx_req_regs
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MBX_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              consume,
    output req_area_t         area,
    output logic              pend
);

    logic [BYTE_W-1:0] bytes_q [REQ_BYTES];
    logic              set_hit;

    assign set_hit = wr_en && (addr == ADDR_W'(OFF_DB_SET)) && wdata[MBX_BIT];

    // Request bytes are locked while a doorbell is outstanding
    generate
        for (genvar i = 0; i < REQ_BYTES; i++) begin : g_req_byte
            always_ff @(posedge clk) begin
                if (rst)
                    bytes_q[i] <= '0;
                else if (wr_en && !pend && (addr == ADDR_W'(OFF_REQ_BASE + i)))
                    bytes_q[i] <= wdata;
            end
        end
    endgenerate

    assign area.op     = bytes_q[0];
    assign area.fields = bytes_q[1];
    assign area.target = bytes_q[2];
    assign area.data   = bytes_q[3];

    // A set in the same cycle as a consume wins
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set_hit)
            pend <= 1'b1;
        else if (consume)
            pend <= 1'b0;
    end

endmodule

// File: rtl/mbx_ack_regs.sv
module mbx_ack_regs
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MBX_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ack_stb,
    input  ack_area_t         ack_in,
    output ack_area_t         area,
    output logic              pend,
    output logic              irq_en,
    output logic              irq
);

    logic clr_hit;
    logic en_hit;

    assign clr_hit = wr_en && (addr == ADDR_W'(OFF_ACK_CLR)) && wdata[MBX_BIT];
    assign en_hit  = wr_en && (addr == ADDR_W'(OFF_IRQ_EN));

    always_ff @(posedge clk) begin
        if (rst)
            area <= '0;
        else if (ack_stb)
            area <= ack_in;
    end

    // Setting by the helper outranks a host clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (ack_stb)
            pend <= 1'b1;
        else if (clr_hit)
            pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_en <= 1'b0;
        else if (en_hit)
            irq_en <= wdata[0];
    end

    assign irq = pend & irq_en;

endmodule

// File: rtl/mbx_readback.sv
module mbx_readback
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MBX_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  req_area_t         req,
    input  logic              db_pend,
    input  ack_area_t         ack,
    input  logic              ack_pend,
    input  logic              irq_en,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] sel;

    always_comb begin
        sel = '0;
        case (int'(addr))
            OFF_REQ_BASE + 0: sel = req.op;
            OFF_REQ_BASE + 1: sel = req.fields;
            OFF_REQ_BASE + 2: sel = req.target;
            OFF_REQ_BASE + 3: sel = req.data;
            OFF_DB_VAL:       sel[MBX_BIT] = db_pend;
            OFF_ACK_FLAG:     sel[MBX_BIT] = ack_pend;
            OFF_ACK_STAT:     sel = ack.status;
            OFF_ACK_BANK:     sel = ack.bank;
            OFF_ACK_TGT:      sel = ack.target;
            OFF_ACK_DATA:     sel = ack.value;
            OFF_IRQ_EN:       sel[0] = irq_en;
            default:          sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= sel;
    end

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MBX_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              req_valid,
    output logic [BYTE_W-1:0] req_op,
    output logic [BYTE_W-1:0] req_fields,
    output logic [BYTE_W-1:0] req_target,
    output logic [BYTE_W-1:0] req_data,
    output logic [BANK_W-1:0] req_bank,
    output logic              req_read,
    input  logic              rsp_consume,
    input  logic              rsp_ack,
    input  logic [BYTE_W-1:0] rsp_status,
    input  logic [BYTE_W-1:0] rsp_bank,
    input  logic [BYTE_W-1:0] rsp_target,
    input  logic [BYTE_W-1:0] rsp_value,
    output logic              irq
);

    req_area_t req_area;
    ack_area_t ack_in;
    ack_area_t ack_area;
    logic      db_pend;
    logic      ack_pend;
    logic      irq_en;

    assign ack_in.status = rsp_status;
    assign ack_in.bank   = rsp_bank;
    assign ack_in.target = rsp_target;
    assign ack_in.value  = rsp_value;

    mbx_req_regs #(.ADDR_W(ADDR_W), .MBX_BIT(MBX_BIT)) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .consume (rsp_consume),
        .area    (req_area),
        .pend    (db_pend)
    );

    mbx_ack_regs #(.ADDR_W(ADDR_W), .MBX_BIT(MBX_BIT)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .ack_stb (rsp_ack),
        .ack_in  (ack_in),
        .area    (ack_area),
        .pend    (ack_pend),
        .irq_en  (irq_en),
        .irq     (irq)
    );

    mbx_readback #(.ADDR_W(ADDR_W), .MBX_BIT(MBX_BIT)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (host_rd),
        .addr     (host_addr),
        .req      (req_area),
        .db_pend  (db_pend),
        .ack      (ack_area),
        .ack_pend (ack_pend),
        .irq_en   (irq_en),
        .rdata    (host_rdata)
    );

    assign req_valid  = db_pend;
    assign req_op     = req_area.op;
    assign req_fields = req_area.fields;
    assign req_target = req_area.target;
    assign req_data   = req_area.data;
    assign req_bank   = op_bank(req_area.op);
    assign req_read   = op_is_read(req_area.op);

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MBX_BIT = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [BYTE_W-1:0] host_wdata,
    input logic              rsp_consume,
    input logic              rsp_ack,
    input logic              req_valid,
    input logic [BYTE_W-1:0] req_op,
    input logic              ack_pend,
    input logic              irq
);

    logic db_set_wr;
    logic ack_clr_wr;

    assign db_set_wr  = host_wr && (host_addr == ADDR_W'(OFF_DB_SET)) && host_wdata[MBX_BIT];
    assign ack_clr_wr = host_wr && (host_addr == ADDR_W'(OFF_ACK_CLR)) && host_wdata[MBX_BIT];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!req_valid && !irq));

    assert_doorbell_rings_R3: assert property (@(posedge clk) disable iff (rst)
        db_set_wr |=> req_valid);

    assert_consume_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_consume && !db_set_wr) |=> !req_valid);

    assert_request_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && host_wr && (host_addr == ADDR_W'(OFF_REQ_BASE))) |=> $stable(req_op));

    assert_ack_sets_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_ack |=> ack_pend);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_clr_wr && !rsp_ack) |=> !ack_pend);

    assert_irq_needs_ack_R9: assert property (@(posedge clk) disable iff (rst)
        !ack_pend |-> !irq);

endmodule

bind mbx_doorbell mbx_doorbell_chk #(.ADDR_W(ADDR_W), .MBX_BIT(MBX_BIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .rsp_consume (rsp_consume),
    .rsp_ack     (rsp_ack),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .ack_pend    (ack_pend),
    .irq         (irq)
);

// File: tb/mbx_doorbell_tb.sv
module mbx_doorbell_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       req_valid;
    logic [7:0] req_op, req_fields, req_target, req_data;
    logic [4:0] req_bank;
    logic       req_read;
    logic       rsp_consume = 1'b0;
    logic       rsp_ack = 1'b0;
    logic [7:0] rsp_status = '0, rsp_bank = '0, rsp_target = '0, rsp_value = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_doorbell u_dut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_op(req_op), .req_fields(req_fields),
        .req_target(req_target), .req_data(req_data),
        .req_bank(req_bank), .req_read(req_read),
        .rsp_consume(rsp_consume), .rsp_ack(rsp_ack),
        .rsp_status(rsp_status), .rsp_bank(rsp_bank),
        .rsp_target(rsp_target), .rsp_value(rsp_value),
        .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'(a);
        @(negedge clk);
        host_rd = 1'b0;
        d = int'(host_rdata);
    endtask

    task automatic consume_pulse();
        @(negedge clk);
        rsp_consume = 1'b1;
        @(negedge clk);
        rsp_consume = 1'b0;
    endtask

    task automatic ack_pulse(input int st, input int bk, input int tg, input int vl);
        @(negedge clk);
        rsp_ack = 1'b1;
        rsp_status = 8'(st); rsp_bank = 8'(bk); rsp_target = 8'(tg); rsp_value = 8'(vl);
        @(negedge clk);
        rsp_ack = 1'b0;
    endtask

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 req_valid", int'(req_valid), 0);
        check("R1 irq", int'(irq), 0);
        for (int a = 0; a < 16; a++) begin
            bus_read(a, v);
            check("R1 reset readback", v, 0);
        end

        // R10: operation byte decode over every bank and direction
        for (int b = 0; b < 32; b++) begin
            for (int r = 0; r < 2; r++) begin
                bus_write(0, 64 + b * 2 + r);
                check("R10 req_bank", int'(req_bank), b);
                check("R10 req_read", int'(req_read), r);
            end
        end
        bus_read(0, v);
        check("R2 op readback", v, 64 + 31 * 2 + 1);

        // R2: request bytes
        bus_write(0, 64 + 9 * 2);
        bus_write(1, 8);
        bus_write(2, 'h5A);
        bus_write(3, 'hC3);
        check("R2 req_op", int'(req_op), 'h52);
        check("R2 req_fields", int'(req_fields), 8);
        check("R2 req_target", int'(req_target), 'h5A);
        check("R2 req_data", int'(req_data), 'hC3);
        bus_read(3, v);
        check("R2 data readback", v, 'hC3);

        // R3: only bit 5 of the set register rings the doorbell
        for (int k = 0; k < 8; k++) begin
            if (k != 5) begin
                bus_write(4, 1 << k);
                check("R3 other bit ignored", int'(req_valid), 0);
            end
        end
        bus_read(5, v);
        check("R3 doorbell idle", v, 0);
        bus_write(4, 'h20);
        check("R3 req_valid", int'(req_valid), 1);
        bus_read(5, v);
        check("R3 doorbell value", v, 'h20);
        bus_read(4, v);
        check("R3 set reads zero", v, 0);

        // R5: request area locked while pending
        bus_write(0, 'h11);
        bus_write(3, 'h00);
        check("R5 op locked", int'(req_op), 'h52);
        check("R5 data locked", int'(req_data), 'hC3);
        bus_read(0, v);
        check("R5 op readback", v, 'h52);

        // R4: consume, idle consume, set-versus-consume priority
        consume_pulse();
        check("R4 consume clears", int'(req_valid), 0);
        consume_pulse();
        check("R4 idle consume", int'(req_valid), 0);
        bus_write(4, 'h20);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'(4); host_wdata = 8'h20; rsp_consume = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; rsp_consume = 1'b0;
        check("R4 set wins over consume", int'(req_valid), 1);
        consume_pulse();
        check("R4 consume after priority", int'(req_valid), 0);
        bus_write(0, 'h11);
        check("R5 unlocked after consume", int'(req_op), 'h11);

        // R6: acknowledge capture
        ack_pulse('h01, 64 + 7 * 2 + 1, 'h33, 'h9E);
        bus_read(6, v);
        check("R6 ack value", v, 'h20);
        bus_read(8, v);
        check("R6 status", v, 'h01);
        bus_read(9, v);
        check("R6 bank recovered", (v >> 1) & 31, 7);
        bus_read(10, v);
        check("R6 target", v, 'h33);
        bus_read(11, v);
        check("R6 value", v, 'h9E);

        // R9: enable gates the interrupt
        check("R9 irq disabled", int'(irq), 0);
        bus_write(12, 1);
        check("R9 irq enabled", int'(irq), 1);
        bus_read(12, v);
        check("R9 enable readback", v, 1);

        // R7: clear register
        for (int k = 0; k < 8; k++) begin
            if (k != 5) begin
                bus_write(7, 1 << k);
                check("R7 other bit ignored", int'(irq), 1);
            end
        end
        bus_read(7, v);
        check("R7 clear reads zero", v, 0);
        bus_write(7, 'h20);
        check("R7 irq cleared", int'(irq), 0);
        bus_read(6, v);
        check("R7 ack value cleared", v, 0);

        // R8: simultaneous acknowledge and clear
        ack_pulse('h02, 0, 0, 0);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'(7); host_wdata = 8'h20;
        rsp_ack = 1'b1; rsp_status = 8'h44;
        @(negedge clk);
        host_wr = 1'b0; rsp_ack = 1'b0;
        check("R8 ack stays", int'(irq), 1);
        bus_read(8, v);
        check("R8 new status", v, 'h44);

        // R9: disable with acknowledge still pending
        bus_write(12, 0);
        check("R9 irq masked", int'(irq), 0);
        bus_read(6, v);
        check("R9 ack still pending", v, 'h20);

        // R11: unmapped offsets
        for (int a = 13; a < 16; a++) begin
            bus_write(a, 'hFF);
            bus_read(a, v);
            check("R11 unmapped reads zero", v, 0);
        end
        check("R11 no doorbell side effect", int'(req_valid), 0);
        check("R11 no irq side effect", int'(irq), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule